// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block sits in a storage host port between the software-visible command-issue register and the engine that fetches command frames and moves their data. Software first loads a small attribute record for a slot: transfer kind, queued or not, unload-type, and whether the command may only use programmed I/O. It then sets that slot's bit in the issue register. The scheduler picks one issued slot at a time and offers its index and attributes to the fetch engine over a valid/ready handshake. It does not pick another slot until the attached device reports busy, data-request and error all low. A completion pulse carrying a slot index clears that slot's issue bit.

Selection rotates. The search starts at the slot after the one most recently handed out and wraps at the top, so every slot is eventually served. Before a slot is offered, the scheduler checks whether it may be mixed with the commands already outstanding. A queued command may not be in flight together with a plain command, and the reverse is also refused. Unload-type commands are exempt from this check. A refused mix, or a device error raised while a command is in flight, stops all issue. It also latches a sticky error flag and the index of the offending slot until software clears the flag. A separate path turns the tag in the device's DMA setup indication into the slot index whose scatter/gather list the transfer uses.

Top module: `slot_issue_sched`

## Requirements
- R1: A synchronous active-high `rst` clears every issue bit, every slot attribute, the rotation pointer (the next search starts at slot 0), the error flag and any pending offer.
- R2: An issue write ORs `issueWrData` into the issue register. Zero bits and bits already set have no effect. A `doneValid` pulse clears bit `doneSlot` in the next cycle. `ciOut` shows the register.
- R3: The next slot offered is the first issued, not yet handed-out slot found by searching upward from the slot after the last accepted one, wrapping from the top slot to slot 0.
- R4: Once `fetchValid` is raised, it stays high and `fetchSlot`, `fetchKind` and `fetchQueued` stay unchanged until the cycle in which `fetchReady` is high. Only one slot is offered at a time.
- R5: No slot is selected unless `devBusy`, `devDataReq` and `devError` are all low. After a handshake, no new offer is made until the device shows all three low.
- R6: `fetchKind` uses 2'b00 for DMA, 2'b01 for PIO and 2'b10 for ATAPI, taken from the slot's attribute. A slot whose PIO-only attribute is set is always offered as 2'b01.
- R7: If the candidate slot is non-queued and a queued slot is outstanding, or the candidate is queued and a non-queued, non-unload slot is outstanding, the slot is not offered. In that case `errFlag` rises and `errSlot` takes the candidate's index. Outstanding means handed out and not yet completed.
- R8: A slot whose unload attribute is set is offered even while slots of the other queuing class are outstanding, and it raises no error.
- R9: `devError` high while the scheduler waits after a handshake raises `errFlag` and sets `errSlot` to the slot handed out last.
- R10: `errFlag` stays high until an `errClr` pulse. While it is high no slot is offered. After it clears, issue resumes.
- R11: A `dmaSetupValid` pulse whose tag names an issued, queued slot gives `sgValid` high with `sgSlot` equal to that tag one cycle later. Any other tag leaves `sgValid` low.
- R12: `fetchQueued` carries the queued attribute of the offered slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueWrEn | input | 1 | Issue register write strobe |
| issueWrData | input | NUM_SLOTS | Bits to set in the issue register |
| attrWrEn | input | 1 | Slot attribute write strobe |
| attrSlot | input | SLOT_W | Slot whose attributes are written |
| attrKind | input | 2 | Transfer kind: 00 DMA, 01 PIO, 10 ATAPI |
| attrQueued | input | 1 | Slot holds a queued command |
| attrUnload | input | 1 | Slot holds an unload command (exempt from mix check) |
| attrPioOnly | input | 1 | Command must be sent as PIO |
| devBusy | input | 1 | Device busy status |
| devDataReq | input | 1 | Device data-request status |
| devError | input | 1 | Device error status |
| fetchValid | output | 1 | Slot offer to the fetch engine |
| fetchReady | input | 1 | Fetch engine accepts the offer |
| fetchSlot | output | SLOT_W | Offered slot index |
| fetchKind | output | 2 | Transfer kind of the offered slot |
| fetchQueued | output | 1 | Offered slot is queued |
| doneValid | input | 1 | Slot completion pulse |
| doneSlot | input | SLOT_W | Completed slot index |
| dmaSetupValid | input | 1 | Device DMA setup indication |
| dmaSetupTag | input | SLOT_W | Tag carried by the DMA setup indication |
| sgValid | output | 1 | Scatter/gather slot selection valid |
| sgSlot | output | SLOT_W | Slot whose scatter/gather list is used |
| errClr | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky error flag; issue halted |
| errSlot | output | SLOT_W | Index of the offending slot |
| ciOut | output | NUM_SLOTS | Current issue register |

## Verification
The rotation vectors set pairs of bits on either side of the pointer, including slots 0 and 31 together. A search that restarted at slot 0 or failed to wrap would hand out the wrong index. The bench holds data-request high across a handshake with a second slot pending, so a scheduler that advanced without status gating would offer early. A plain command is issued behind an outstanding queued one, and an unload command behind another. A missing or over-broad mix check would then either offer a slot it must refuse or flag one it must accept. A device error is raised while a slot is in flight with a further slot pending. Recording the wrong slot, or issuing before the flag is cleared, shows up at `errSlot` and `fetchValid`.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  typedef enum logic [1:0] {
    KIND_DMA   = 2'b00,
    KIND_PIO   = 2'b01,
    KIND_ATAPI = 2'b10
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      queued;
    logic      unload;
    logic      pioOnly;
  } slot_attr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCur;   // capture candidate as current slot
    logic accept;     // fetch handshake done: mark sent, advance pointer
    logic errViol;    // mixing violation on candidate
    logic errDev;     // device error while current slot in flight
  } ctrl_strobe_t;

endpackage

// File: rtl/slot_sched_dp.sv
module slot_sched_dp
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_strobe_t         strobe,
  input  logic                 issueWrEn,
  input  logic [NUM_SLOTS-1:0] issueWrData,
  input  logic                 attrWrEn,
  input  logic [SLOT_W-1:0]    attrSlot,
  input  slot_attr_t           attrIn,
  input  logic                 doneValid,
  input  logic [SLOT_W-1:0]    doneSlot,
  input  logic                 dmaSetupValid,
  input  logic [SLOT_W-1:0]    dmaSetupTag,
  input  logic                 errClr,
  output logic                 candValid,
  output logic                 candViol,
  output logic [SLOT_W-1:0]    curSlot,
  output logic [1:0]           curKind,
  output logic                 curQueued,
  output logic                 sgValid,
  output logic [SLOT_W-1:0]    sgSlot,
  output logic                 errFlag,
  output logic [SLOT_W-1:0]    errSlot,
  output logic [NUM_SLOTS-1:0] ciReg
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  slot_attr_t            attrMem [NUM_SLOTS];
  slot_attr_t            curAttr;
  logic [NUM_SLOTS-1:0]  sentReg;
  logic [NUM_SLOTS-1:0]  queuedMask;
  logic [NUM_SLOTS-1:0]  unloadMask;
  logic [NUM_SLOTS-1:0]  pendMask;
  logic [NUM_SLOTS-1:0]  outMask;
  logic [NUM_SLOTS-1:0]  doneMask;
  logic [NUM_SLOTS-1:0]  acceptMask;
  logic [SLOT_W-1:0]     nextPtr;
  logic [SLOT_W-1:0]     candSlot;
  logic                  outQueued;
  logic                  outPlain;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    assign queuedMask[g] = attrMem[g].queued;
    assign unloadMask[g] = attrMem[g].unload;
  end

  assign pendMask   = ciReg & ~sentReg;
  assign outMask    = ciReg & sentReg;
  assign outQueued  = |(outMask & queuedMask);
  assign outPlain   = |(outMask & ~queuedMask & ~unloadMask);
  assign doneMask   = doneValid ? (NUM_SLOTS'(1) << doneSlot) : '0;
  assign acceptMask = strobe.accept ? (NUM_SLOTS'(1) << curSlot) : '0;

  // rotating search: lowest offset from nextPtr wins (loop runs downward)
  always_comb begin
    candValid = 1'b0;
    candSlot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pendMask[(int'(nextPtr) + i) % NUM_SLOTS]) begin
        candValid = 1'b1;
        candSlot  = SLOT_W'((int'(nextPtr) + i) % NUM_SLOTS);
      end
    end
  end

  // unload commands are exempt from the queued/plain mixing rule
  always_comb begin
    if (unloadMask[candSlot])      candViol = 1'b0;
    else if (queuedMask[candSlot]) candViol = outPlain;
    else                           candViol = outQueued;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) attrMem[i] <= '0;
    end else if (attrWrEn) begin
      attrMem[attrSlot] <= attrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ciReg   <= '0;
      sentReg <= '0;
      nextPtr <= '0;
      curSlot <= '0;
      curAttr <= '0;
    end else begin
      ciReg   <= (ciReg & ~doneMask) | (issueWrEn ? issueWrData : '0);
      sentReg <= (sentReg & ~doneMask) | acceptMask;
      if (strobe.latchCur) begin
        curSlot <= candSlot;
        curAttr <= attrMem[candSlot];
      end
      if (strobe.accept)
        nextPtr <= (curSlot == LAST_SLOT) ? '0 : curSlot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errFlag <= 1'b0;
      errSlot <= '0;
    end else if (strobe.errViol) begin
      errFlag <= 1'b1;
      errSlot <= candSlot;
    end else if (strobe.errDev) begin
      errFlag <= 1'b1;
      errSlot <= curSlot;
    end else if (errClr) begin
      errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sgValid <= 1'b0;
      sgSlot  <= '0;
    end else begin
      sgValid <= dmaSetupValid && ciReg[dmaSetupTag] && queuedMask[dmaSetupTag];
      sgSlot  <= dmaSetupTag;
    end
  end

  assign curKind   = curAttr.pioOnly ? KIND_PIO : curAttr.kind;
  assign curQueued = curAttr.queued;

endmodule

// File: rtl/slot_sched_ctrl.sv
module slot_sched_ctrl
  import slot_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         candValid,
  input  logic         candViol,
  input  logic         errFlag,
  input  logic         devClear,
  input  logic         devError,
  input  logic         fetchReady,
  output logic         fetchValid,
  output ctrl_strobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_WAIT} sched_state_e;

  sched_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!errFlag && devClear && candValid) begin
          if (candViol) begin
            strobe.errViol = 1'b1;
          end else begin
            strobe.latchCur = 1'b1;
            stateNext       = ST_OFFER;
          end
        end
      end
      ST_OFFER: begin
        if (fetchReady) begin
          strobe.accept = 1'b1;
          stateNext     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (devError) begin
          strobe.errDev = 1'b1;
          stateNext     = ST_IDLE;
        end else if (devClear) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign fetchValid = (state == ST_OFFER);

endmodule

// File: rtl/slot_issue_sched.sv
module slot_issue_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issueWrEn,
  input  logic [NUM_SLOTS-1:0] issueWrData,
  input  logic                 attrWrEn,
  input  logic [SLOT_W-1:0]    attrSlot,
  input  logic [1:0]           attrKind,
  input  logic                 attrQueued,
  input  logic                 attrUnload,
  input  logic                 attrPioOnly,
  input  logic                 devBusy,
  input  logic                 devDataReq,
  input  logic                 devError,
  output logic                 fetchValid,
  input  logic                 fetchReady,
  output logic [SLOT_W-1:0]    fetchSlot,
  output logic [1:0]           fetchKind,
  output logic                 fetchQueued,
  input  logic                 doneValid,
  input  logic [SLOT_W-1:0]    doneSlot,
  input  logic                 dmaSetupValid,
  input  logic [SLOT_W-1:0]    dmaSetupTag,
  output logic                 sgValid,
  output logic [SLOT_W-1:0]    sgSlot,
  input  logic                 errClr,
  output logic                 errFlag,
  output logic [SLOT_W-1:0]    errSlot,
  output logic [NUM_SLOTS-1:0] ciOut
);

  ctrl_strobe_t strobe;
  slot_attr_t   attrIn;
  logic         candValid;
  logic         candViol;
  logic         devClear;

  assign devClear = !devBusy && !devDataReq && !devError;
  assign attrIn   = '{kind: cmd_kind_e'(attrKind), queued: attrQueued,
                      unload: attrUnload, pioOnly: attrPioOnly};

  slot_sched_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .candValid  (candValid),
    .candViol   (candViol),
    .errFlag    (errFlag),
    .devClear   (devClear),
    .devError   (devError),
    .fetchReady (fetchReady),
    .fetchValid (fetchValid),
    .strobe     (strobe)
  );

  slot_sched_dp #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .issueWrEn     (issueWrEn),
    .issueWrData   (issueWrData),
    .attrWrEn      (attrWrEn),
    .attrSlot      (attrSlot),
    .attrIn        (attrIn),
    .doneValid     (doneValid),
    .doneSlot      (doneSlot),
    .dmaSetupValid (dmaSetupValid),
    .dmaSetupTag   (dmaSetupTag),
    .errClr        (errClr),
    .candValid     (candValid),
    .candViol      (candViol),
    .curSlot       (fetchSlot),
    .curKind       (fetchKind),
    .curQueued     (fetchQueued),
    .sgValid       (sgValid),
    .sgSlot        (sgSlot),
    .errFlag       (errFlag),
    .errSlot       (errSlot),
    .ciReg         (ciOut)
  );

endmodule

// File: rtl/slot_issue_sched_chk.sv
module slot_issue_sched_chk #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 issueWrEn,
  input logic [NUM_SLOTS-1:0] issueWrData,
  input logic                 devBusy,
  input logic                 devDataReq,
  input logic                 devError,
  input logic                 fetchValid,
  input logic                 fetchReady,
  input logic [SLOT_W-1:0]    fetchSlot,
  input logic [1:0]           fetchKind,
  input logic                 doneValid,
  input logic [SLOT_W-1:0]    doneSlot,
  input logic                 dmaSetupValid,
  input logic [SLOT_W-1:0]    dmaSetupTag,
  input logic                 sgValid,
  input logic [SLOT_W-1:0]    sgSlot,
  input logic                 errClr,
  input logic                 errFlag,
  input logic [NUM_SLOTS-1:0] ciOut
);

  // set by a fully clear device status, cleared by each handshake
  logic gateOk;
  always_ff @(posedge clk) begin
    if (rst)                                gateOk <= 1'b1;
    else if (fetchValid && fetchReady)      gateOk <= 1'b0;
    else if (!devBusy && !devDataReq && !devError) gateOk <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ciOut == '0 && !errFlag && !fetchValid));

  p_done_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !(issueWrEn && issueWrData[doneSlot])) |=> !ciOut[$past(doneSlot)]);

  p_hold_offer_r4: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && !fetchReady) |=> (fetchValid && $stable(fetchSlot) && $stable(fetchKind)));

  p_offer_issued_r4: assert property (@(posedge clk) disable iff (rst)
    fetchValid |-> ciOut[fetchSlot]);

  p_gate_status_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fetchValid) |-> gateOk);

  p_halt_on_err_r10: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> !fetchValid);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (errFlag && !errClr) |=> errFlag);

  p_sg_tag_r11: assert property (@(posedge clk) disable iff (rst)
    sgValid |-> ($past(dmaSetupValid) && sgSlot == $past(dmaSetupTag)));

endmodule

bind slot_issue_sched slot_issue_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/sim_slot_issue_sched.sv
module sim_slot_issue_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issueWrEn = 1'b0;
  logic [NS-1:0] issueWrData = '0;
  logic          attrWrEn = 1'b0;
  logic [SW-1:0] attrSlot = '0;
  logic [1:0]    attrKind = '0;
  logic          attrQueued = 1'b0, attrUnload = 1'b0, attrPioOnly = 1'b0;
  logic          devBusy = 1'b0, devDataReq = 1'b0, devError = 1'b0;
  logic          fetchValid, fetchReady = 1'b0, fetchQueued;
  logic [SW-1:0] fetchSlot;
  logic [1:0]    fetchKind;
  logic          doneValid = 1'b0;
  logic [SW-1:0] doneSlot = '0;
  logic          dmaSetupValid = 1'b0;
  logic [SW-1:0] dmaSetupTag = '0;
  logic          sgValid, errClr = 1'b0, errFlag;
  logic [SW-1:0] sgSlot, errSlot;
  logic [NS-1:0] ciOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_issue_sched #(.NUM_SLOTS(NS)) u0 (.*);

  // {issue mask, expected slot offered}
  localparam logic [36:0] VEC [7] = '{
    {32'h0000_0001, 5'd0},
    {32'h8000_0001, 5'd31},
    {32'h0000_0000, 5'd0},
    {32'h0000_0014, 5'd2},
    {32'h0000_0000, 5'd4},
    {32'h0000_0011, 5'd0},
    {32'h0000_0000, 5'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [NS-1:0] mask);
    issueWrEn = 1'b1; issueWrData = mask;
    @(negedge clk);
    issueWrEn = 1'b0; issueWrData = '0;
  endtask

  task automatic setAttr(input int slot, input logic [1:0] kind, input logic q,
                         input logic u, input logic p);
    attrWrEn = 1'b1; attrSlot = SW'(slot); attrKind = kind;
    attrQueued = q; attrUnload = u; attrPioOnly = p;
    @(negedge clk);
    attrWrEn = 1'b0;
  endtask

  task automatic finishSlot(input int slot);
    doneValid = 1'b1; doneSlot = SW'(slot);
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic clearErr();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  task automatic waitOffer(input string req);
    int n = 0;
    while (!fetchValid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk({req, " offer"}, 32'(fetchValid), 32'd1);
  endtask

  task automatic pulseReady();
    fetchReady = 1'b1;
    @(negedge clk);
    fetchReady = 1'b0;
  endtask

  task automatic serve(input string req, input int expSlot, input int expKind,
                       input logic expQ, input bit doDone);
    waitOffer(req);
    chk({req, " slot"}, 32'(fetchSlot), 32'(expSlot));
    chk({req, " kind"}, 32'(fetchKind), 32'(expKind));
    chk({req, " queued"}, 32'(fetchQueued), 32'(expQ));
    pulseReady();
    if (doDone) finishSlot(expSlot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 ciOut", ciOut, 0);
    chk("R1 fetchValid", 32'(fetchValid), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    chk("R1 sgValid", 32'(sgValid), 0);

    // R3: rotating selection from the vector table
    foreach (VEC[k]) begin
      if (VEC[k][36:5] != 0) issue(VEC[k][36:5]);
      serve("R3", int'(VEC[k][4:0]), 0, 1'b0, 1'b1);
    end
    chk("R3 drained", ciOut, 0);

    // R2: set-only writes and completion clears, with device held busy
    devBusy = 1'b1;
    issue(32'h0000_0300);
    chk("R2 set", ciOut, 32'h0000_0300);
    issue(32'h0);
    chk("R2 zero write", ciOut, 32'h0000_0300);
    issue(32'h0000_0100);
    chk("R2 rewrite", ciOut, 32'h0000_0300);
    finishSlot(9);
    chk("R2 done9", ciOut, 32'h0000_0100);
    finishSlot(8);
    chk("R2 done8", ciOut, 32'h0);
    chk("R5 busy no offer", 32'(fetchValid), 0);
    devBusy = 1'b0;

    // R5: data request held across a handshake blocks the next offer
    issue(32'h0000_0060);
    waitOffer("R5");
    chk("R5 first slot", 32'(fetchSlot), 5);
    devDataReq = 1'b1;
    pulseReady();
    for (int i = 0; i < 4; i++) begin
      chk("R5 gated", 32'(fetchValid), 0);
      @(negedge clk);
    end
    devDataReq = 1'b0;
    serve("R5", 6, 0, 1'b0, 1'b1);
    finishSlot(5);

    // R6 / R4: kind encoding, PIO-only override, offer held while not ready
    setAttr(10, 2'b10, 1'b0, 1'b0, 1'b0);
    issue(32'h1 << 10);
    waitOffer("R4");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 held valid", 32'(fetchValid), 1);
      chk("R4 held slot", 32'(fetchSlot), 10);
    end
    serve("R6 atapi", 10, 2, 1'b0, 1'b1);
    setAttr(11, 2'b10, 1'b0, 1'b0, 1'b1);
    issue(32'h1 << 11);
    serve("R6 pio-only", 11, 1, 1'b0, 1'b1);

    // R12 / R7 / R10: plain command behind an outstanding queued one
    setAttr(13, 2'b00, 1'b1, 1'b0, 1'b0);
    issue(32'h1 << 13);
    serve("R12 queued", 13, 0, 1'b1, 1'b0);
    issue(32'h1 << 14);
    repeat (3) @(negedge clk);
    chk("R7 errFlag", 32'(errFlag), 1);
    chk("R7 errSlot", 32'(errSlot), 14);
    chk("R7 no offer", 32'(fetchValid), 0);
    repeat (5) @(negedge clk);
    chk("R10 sticky", 32'(errFlag), 1);
    finishSlot(13);
    chk("R10 halted", 32'(fetchValid), 0);
    clearErr();
    chk("R10 cleared", 32'(errFlag), 0);
    serve("R10 resume", 14, 0, 1'b0, 1'b1);

    // R11 / R8: scatter/gather tag and the unload exemption
    setAttr(15, 2'b00, 1'b1, 1'b0, 1'b0);
    issue(32'h1 << 15);
    serve("R12 queued2", 15, 0, 1'b1, 1'b0);
    dmaSetupValid = 1'b1; dmaSetupTag = 5'd15;
    @(negedge clk);
    dmaSetupValid = 1'b0;
    chk("R11 sgValid", 32'(sgValid), 1);
    chk("R11 sgSlot", 32'(sgSlot), 15);
    dmaSetupValid = 1'b1; dmaSetupTag = 5'd20;
    @(negedge clk);
    dmaSetupValid = 1'b0;
    chk("R11 unissued tag", 32'(sgValid), 0);
    setAttr(16, 2'b00, 1'b0, 1'b1, 1'b0);
    issue(32'h1 << 16);
    serve("R8 unload", 16, 0, 1'b0, 1'b1);
    chk("R8 no error", 32'(errFlag), 0);
    finishSlot(15);

    // R9: device error while a slot is in flight
    issue(32'h1 << 17);
    waitOffer("R9");
    chk("R9 slot", 32'(fetchSlot), 17);
    devBusy = 1'b1;
    pulseReady();
    issue(32'h1 << 18);
    devError = 1'b1;
    @(negedge clk);
    devError = 1'b0;
    devBusy  = 1'b0;
    chk("R9 errFlag", 32'(errFlag), 1);
    chk("R9 errSlot", 32'(errSlot), 17);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 halted", 32'(fetchValid), 0);
    end
    finishSlot(17);
    clearErr();
    serve("R9 resume", 18, 0, 1'b0, 1'b1);

    // R1: reset during activity
    devBusy = 1'b1;
    issue(32'h0000_0007);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 midrun ciOut", ciOut, 0);
    devBusy = 1'b0;
    issue(32'h0000_0004);
    serve("R1 pointer", 2, 0, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule